// File: doc/BRIEF.md
# Synthesizer Control Register Slave on a Two-Wire Bus

This block is the register front end of a tuning synthesizer. It listens on an I2C bus as a slave and answers one of four addresses: the upper five address bits are fixed and the lower two come from a strap input. This lets four synthesizers share one bus. SCL and SDA are sampled by the system clock through two-flop synchronisers. The slave drives SDA only as an open-drain pull-down enable.

In a write transfer, each data byte that starts a pair is classified by its top bit. A 0 marks a frequency pair that carries a 10-bit main ratio and a 5-bit swallow ratio. A 1 marks a control byte, which is always followed by a band-switch byte. The values of a pair go to the output registers together, when its second byte completes. A pair that is left unfinished changes nothing.

In a read transfer, the slave returns a status byte that carries the loop-lock flag and a 3-bit converter code. It keeps resending that byte while the master acknowledges and stops after a NACK.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave responds only to the 7-bit address {1,1,0,0,0,strap_addr[1],strap_addr[0]}. For any other address it gives no acknowledge, and the data bytes that follow leave every output register unchanged.
- R2: The eighth address bit selects the direction: 0 makes the slave receive data bytes and 1 makes it transmit status bytes.
- R3: A pair whose first byte has bit 7 = 0 is a frequency pair. freq_m is set to {first[6:0], second[7:5]} and freq_s is set to second[4:0].
- R4: A pair whose first byte has bit 7 = 1 is a control pair. In the control byte, bit 6 drives pump_hi, bit 4 drives pump_off, bits 2:1 drive ref_ratio and bit 0 drives vt_off. In the second byte, bits 3:0 drive band_en and bits 7:4 are ignored.
- R5: Bytes after an address are taken in consecutive pairs, and the registers of a pair change only when its second byte completes. A transfer that ends after an odd byte keeps the previously committed values.
- R6: A repeated START followed by a matching address restarts the pairing, even when no STOP came first. An unfinished pair from before the repeated START is dropped.
- R7: The status byte sent in a read is {0, lock_i, 1, 1, 1, conv_code[2:0]}, MSB first. It is sampled when each byte is loaded.
- R8: Reset clears freq_m, freq_s, all control outputs and band_en to 0, and releases SDA.
- R9: The slave pulls SDA low during the ninth clock after a matching address and after every write byte. A master NACK after a read byte ends the transfer with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_addr | input | 2 | Low two bits of the slave address |
| lock_i | input | 1 | Loop-lock flag for the status byte |
| conv_code | input | 3 | Converter code for the status byte |
| freq_m | output | 10 | Main divider ratio |
| freq_s | output | 5 | Swallow counter ratio |
| pump_hi | output | 1 | High charge-pump current select |
| pump_off | output | 1 | Charge pump disable |
| vt_off | output | 1 | Tuning voltage output disable |
| ref_ratio | output | 2 | Reference divider select code |
| band_en | output | 4 | Band switch enables |

## Verification
A wrong pairing phase shows up on the register outputs right after the transfer: data lands in the wrong fields, or a lone byte commits when it should not. This is visible within one byte time of the faulty byte. A wrong bit counter or protocol state shows up earlier, as a missing or misplaced acknowledge in the ninth clock of the same byte. A broken read path shows up as a wrong status bit in the same byte, or as SDA still being held after a master NACK.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK
    } link_state_e;

    typedef struct packed {
        link_state_e st;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic        oe;
        logic        rw;
        logic        addr_hit;
        logic        wr_stb;
    } link_regs_t;

    typedef struct packed {
        logic [9:0] m;
        logic [4:0] s;
        logic       cp_hi;
        logic       cp_off;
        logic       vt_off;
        logic [1:0] ref_ratio;
        logic [3:0] band;
        logic       pend_valid;
        logic [7:0] pend;
    } bank_regs_t;

endpackage

// File: rtl/tuner_i2c_sync.sv
module tuner_i2c_sync #(
    parameter int NSYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] cur;
    logic [NLINES-1:0] prev_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [NSYNC-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[NSYNC-2:0], raw[g]};
        end
        assign cur[g] = chain_q[NSYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= cur;
    end

    // index 1 is SCL, index 0 is SDA
    assign sda_s     = cur[0];
    assign scl_rise  = cur[1] & ~prev_q[1];
    assign scl_fall  = ~cur[1] & prev_q[1];
    assign start_det = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
    assign stop_det  = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
endmodule

// File: rtl/tuner_i2c_link.sv
module tuner_i2c_link
    import tuner_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [6:0] dev_addr,
    input  logic [7:0] status,
    output logic       sda_oe,
    output logic       addr_hit,
    output logic       wr_stb,
    output logic [7:0] wr_data
);
    localparam logic [3:0] BITS = 4'd8;

    link_regs_t q, n;

    always_comb begin
        n          = q;
        n.addr_hit = 1'b0;
        n.wr_stb   = 1'b0;
        if (start_det) begin
            n.st  = ST_ADDR;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else if (stop_det) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise && q.cnt < BITS) begin
                        n.sh  = {q.sh[6:0], sda_s};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BITS) begin
                        n.cnt = '0;
                        if (q.st == ST_WR) begin
                            n.wr_stb = 1'b1;
                            n.st     = ST_WACK;
                            n.oe     = 1'b1;
                        end else if (q.sh[7:1] == dev_addr) begin
                            n.st       = ST_AACK;
                            n.oe       = 1'b1;
                            n.rw       = q.sh[0];
                            n.addr_hit = 1'b1;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        n.cnt = '0;
                        if (q.rw) begin
                            n.st = ST_RD;
                            n.sh = status;
                            n.oe = ~status[7];
                        end else begin
                            n.st = ST_WR;
                            n.oe = 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        n.st = ST_WR;
                        n.oe = 1'b0;
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (q.cnt == BITS - 4'd1) begin
                            n.st  = ST_RACK;
                            n.oe  = 1'b0;
                            n.cnt = '0;
                        end else begin
                            n.cnt = q.cnt + 4'd1;
                            n.sh  = {q.sh[6:0], 1'b0};
                            n.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise && sda_s) begin
                        n.st = ST_IDLE;
                    end else if (scl_fall) begin
                        n.st  = ST_RD;
                        n.sh  = status;
                        n.oe  = ~status[7];
                        n.cnt = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= n;
    end

    assign sda_oe   = q.oe;
    assign addr_hit = q.addr_hit;
    assign wr_stb   = q.wr_stb;
    assign wr_data  = q.sh;
endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
    import tuner_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_hit,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    output logic [9:0] freq_m,
    output logic [4:0] freq_s,
    output logic       pump_hi,
    output logic       pump_off,
    output logic       vt_off,
    output logic [1:0] ref_ratio,
    output logic [3:0] band_en
);
    bank_regs_t q, n;

    always_comb begin
        n = q;
        if (addr_hit) begin
            n.pend_valid = 1'b0;
        end else if (wr_stb) begin
            if (!q.pend_valid) begin
                n.pend       = wr_data;
                n.pend_valid = 1'b1;
            end else begin
                n.pend_valid = 1'b0;
                if (!q.pend[7]) begin
                    n.m = {q.pend[6:0], wr_data[7:5]};
                    n.s = wr_data[4:0];
                end else begin
                    n.cp_hi     = q.pend[6];
                    n.cp_off    = q.pend[4];
                    n.ref_ratio = q.pend[2:1];
                    n.vt_off    = q.pend[0];
                    n.band      = wr_data[3:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign freq_m    = q.m;
    assign freq_s    = q.s;
    assign pump_hi   = q.cp_hi;
    assign pump_off  = q.cp_off;
    assign vt_off    = q.vt_off;
    assign ref_ratio = q.ref_ratio;
    assign band_en   = q.band;
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs #(
    parameter int         NSYNC   = 2,
    parameter logic [4:0] ADDR_HI = 5'b11000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap_addr,
    input  logic       lock_i,
    input  logic [2:0] conv_code,
    output logic [9:0] freq_m,
    output logic [4:0] freq_s,
    output logic       pump_hi,
    output logic       pump_off,
    output logic       vt_off,
    output logic [1:0] ref_ratio,
    output logic [3:0] band_en
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       addr_hit, wr_stb;
    logic [7:0] wr_data;
    logic [6:0] dev_addr;
    logic [7:0] status;

    assign dev_addr = {ADDR_HI, strap_addr};
    assign status   = {1'b0, lock_i, 3'b111, conv_code};

    tuner_i2c_sync #(.NSYNC(NSYNC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tuner_i2c_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .status    (status),
        .sda_oe    (sda_oe),
        .addr_hit  (addr_hit),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data)
    );

    tuner_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_hit  (addr_hit),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .freq_m    (freq_m),
        .freq_s    (freq_s),
        .pump_hi   (pump_hi),
        .pump_off  (pump_off),
        .vt_off    (vt_off),
        .ref_ratio (ref_ratio),
        .band_en   (band_en)
    );
endmodule

// File: rtl/tuner_i2c_regs_chk.sv
module tuner_i2c_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic [9:0] freq_m,
    input logic [4:0] freq_s,
    input logic       pump_hi,
    input logic       pump_off,
    input logic       vt_off,
    input logic [1:0] ref_ratio,
    input logic [3:0] band_en
);
    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (freq_m == '0 && freq_s == '0 && band_en == '0 && !sda_oe));

    // R3, R5: frequency commits happen during the ACK low phase, never with SCL high
    assert_freq_commit_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(freq_m) || !$stable(freq_s)) |-> !scl_i);

    // R4, R5: control and band commits likewise
    assert_ctrl_commit_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(band_en) || !$stable(pump_hi) || !$stable(pump_off) ||
         !$stable(vt_off) || !$stable(ref_ratio)) |-> !scl_i);

    assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);
endmodule

bind tuner_i2c_regs tuner_i2c_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .freq_m    (freq_m),
    .freq_s    (freq_s),
    .pump_hi   (pump_hi),
    .pump_off  (pump_off),
    .vt_off    (vt_off),
    .ref_ratio (ref_ratio),
    .band_en   (band_en)
);

// File: tb/test_tuner_i2c_regs.sv
`timescale 1ns/1ps
module test_tuner_i2c_regs;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [1:0] strap_addr = 2'b10;
    logic lock_i = 1'b0;
    logic [2:0] conv_code = 3'b000;
    logic [9:0] freq_m;
    logic [4:0] freq_s;
    logic pump_hi, pump_off, vt_off;
    logic [1:0] ref_ratio;
    logic [3:0] band_en;
    logic [23:0] obs;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign obs = {freq_m, freq_s, pump_hi, pump_off, vt_off, ref_ratio, band_en};

    tuner_i2c_regs i_tuner_i2c_regs (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_addr(strap_addr), .lock_i(lock_i), .conv_code(conv_code),
        .freq_m(freq_m), .freq_s(freq_s), .pump_hi(pump_hi), .pump_off(pump_off),
        .vt_off(vt_off), .ref_ratio(ref_ratio), .band_en(band_en)
    );

    // {first byte, second byte, expected {m,s,cp_hi,cp_off,vt_off,ref,band}}
    localparam logic [39:0] VEC [4] = '{
        {8'h12, 8'h34, 10'h091, 5'h14, 3'b000, 2'b00, 4'h0},
        {8'hD5, 8'hF9, 10'h091, 5'h14, 3'b111, 2'b10, 4'h9},
        {8'h7F, 8'hFF, 10'h3FF, 5'h1F, 3'b111, 2'b10, 4'h9},
        {8'h80, 8'h06, 10'h3FF, 5'h1F, 3'b000, 2'b00, 4'h6}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] rd;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R8 reset registers", 32'(obs), 32'h0);
        chk("R8 reset sda released", 32'(sda_oe), 32'h0);

        // vector table: one pair per transfer
        for (int i = 0; i < 4; i++) begin
            bus_start;
            put_byte(8'hC4, ack);
            chk("R1 R2 address ack", 32'(ack), 32'h1);
            put_byte(VEC[i][39:32], ack);
            chk("R9 first byte ack", 32'(ack), 32'h1);
            put_byte(VEC[i][31:24], ack);
            bus_stop;
            tick(Q);
            chk(VEC[i][39] ? "R4 control pair" : "R3 frequency pair", 32'(obs), 32'(VEC[i][23:0]));
        end

        // wrong address: no ack and no effect
        bus_start;
        put_byte(8'hC0, ack);
        chk("R1 foreign address not acked", 32'(ack), 32'h0);
        put_byte(8'h12, ack);
        put_byte(8'h34, ack);
        bus_stop;
        tick(Q);
        chk("R1 foreign data ignored", 32'(obs), 32'({10'h3FF, 5'h1F, 3'b000, 2'b00, 4'h6}));

        // odd byte count keeps old values
        bus_start;
        put_byte(8'hC4, ack);
        put_byte(8'h00, ack);
        bus_stop;
        tick(Q);
        chk("R5 partial pair kept", 32'(obs), 32'({10'h3FF, 5'h1F, 3'b000, 2'b00, 4'h6}));

        // two pairs in one transfer
        bus_start;
        put_byte(8'hC4, ack);
        put_byte(8'h01, ack);
        put_byte(8'h02, ack);
        put_byte(8'hA0, ack);
        put_byte(8'h03, ack);
        chk("R9 fourth byte ack", 32'(ack), 32'h1);
        bus_stop;
        tick(Q);
        chk("R5 two pairs one transfer", 32'(obs), 32'({10'h008, 5'h02, 3'b000, 2'b00, 4'h3}));

        // repeated start without stop
        bus_start;
        put_byte(8'hC4, ack);
        put_byte(8'h05, ack);
        bus_start;
        put_byte(8'hC4, ack);
        chk("R6 address after repeated start", 32'(ack), 32'h1);
        put_byte(8'h02, ack);
        put_byte(8'h40, ack);
        bus_stop;
        tick(Q);
        chk("R6 repeated start pairing", 32'(obs), 32'({10'h012, 5'h00, 3'b000, 2'b00, 4'h3}));

        // read with immediate NACK
        lock_i = 1'b1;
        conv_code = 3'b101;
        bus_start;
        put_byte(8'hC5, ack);
        chk("R2 read address ack", 32'(ack), 32'h1);
        get_byte(1'b1, rd);
        chk("R7 status locked", 32'(rd), 32'h7D);
        chk("R9 released after nack", 32'(sda_oe), 32'h0);
        bus_stop;

        // read two bytes: ACK then NACK
        lock_i = 1'b0;
        conv_code = 3'b010;
        bus_start;
        put_byte(8'hC5, ack);
        get_byte(1'b0, rd);
        chk("R7 status unlocked", 32'(rd), 32'h3A);
        get_byte(1'b1, rd);
        chk("R7 status resent after ack", 32'(rd), 32'h3A);
        chk("R9 released after second nack", 32'(sda_oe), 32'h0);
        bus_stop;
        tick(Q);
        chk("R2 read leaves registers", 32'(obs), 32'({10'h012, 5'h00, 3'b000, 2'b00, 4'h3}));

        // reset again with registers loaded
        rst_n = 1'b0;
        tick(3);
        chk("R8 reset clears loaded registers", 32'(obs), 32'h0);
        rst_n = 1'b1;
        tick(Q);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule